// File: doc/BRIEF.md
# Dual-Ring Wrap Controller

This block sits in every node of a fabric built from two rings that run in opposite directions. Ring A flows from the node's upstream neighbour toward its downstream neighbour. Ring B flows the other way. Each side of the node has a link-good input. While both links are good, each ring passes straight through the node and both rings carry traffic.

When a side's link fails, the node turns traffic back at that side. Flits that arrive on one ring leave on the other ring, heading away from the break. If a link between two nodes breaks, both of those nodes do this, and the survivors then form one continuous loop. If a whole node dies, its two neighbours each wrap on the side that faces it. If both of a node's links are down, the node isolates itself and drives idle on both ring outputs.

A side stays wrapped until its link has been seen good for a parameterised number of consecutive cycles. The default is 16. This keeps a flapping link from toggling the ring topology. Detecting link faults and recovering the ring token happen elsewhere.

Top module: `ring_wrap_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, both sides are treated as wrapped: `wrap_status` reads 2'b11 and both ring outputs are idle (valid 0, data 0).
- R2: `wrap_status` bit 0 reports the downstream side as wrapped, and bit 1 reports the upstream side. 2'b00 means pass-through. In pass-through, ring A input appears on ring A output and ring B input on ring B output, one clock after being sampled.
- R3: With status 2'b01 (downstream wrapped), the ring A input sampled at an edge appears on the ring B output after that edge. The ring A output is idle, and the ring B input has no effect on either output.
- R4: With status 2'b10 (upstream wrapped), the ring B input sampled at an edge appears on the ring A output after that edge. The ring B output is idle, and the ring A input has no effect on either output.
- R5: With status 2'b11 (isolated), both outputs are idle whatever arrives on either input.
- R6: A link-good input sampled low at a clock edge sets that side's status bit right after that edge.
- R7: A wrapped side's status bit clears right after the 16th consecutive edge at which its link-good input is sampled high, and not before.
- R8: A single low sample of link-good during that count restarts it from zero.
- R9: The data outputs at each edge are steered by the status held just before that edge, so a status change steers data from the following edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dn_link_ok | input | 1 | Link toward the downstream neighbour is good |
| up_link_ok | input | 1 | Link toward the upstream neighbour is good |
| a_in_vld | input | 1 | Ring A flit valid, arriving from upstream |
| a_in_dat | input | DATA_W | Ring A flit payload, arriving from upstream |
| b_in_vld | input | 1 | Ring B flit valid, arriving from downstream |
| b_in_dat | input | DATA_W | Ring B flit payload, arriving from downstream |
| a_out_vld | output | 1 | Ring A flit valid, leaving toward downstream |
| a_out_dat | output | DATA_W | Ring A flit payload, leaving toward downstream |
| b_out_vld | output | 1 | Ring B flit valid, leaving toward upstream |
| b_out_dat | output | DATA_W | Ring B flit payload, leaving toward upstream |
| wrap_status | output | 2 | Bit 0: downstream side wrapped; bit 1: upstream side wrapped |

## Verification
A flit sampled at an edge is due on the outputs one cycle later, steered by the status held before that edge. A status bit changes right after the edge that samples the low link, or right after the 16th consecutive good sample. The driver task keeps its own model of both sides. At each edge it pushes the expected outputs and the expected post-edge status into a queue. The monitor pops that entry shortly after the same edge and compares, so every comparison lands exactly one register stage after its stimulus. Glitches at count 10 and at count 15 check that the hold window restarts, and stimulus on the ignored input during wraps checks that it has no effect.

// File: rtl/ring_wrap_pkg.sv
package ring_wrap_pkg;

    typedef enum logic [1:0] {
        MODE_PASS    = 2'b00,
        MODE_WRAP_DN = 2'b01,
        MODE_WRAP_UP = 2'b10,
        MODE_ISOLATE = 2'b11
    } wrap_mode_e;

    typedef enum logic [1:0] {
        SRC_IDLE = 2'd0,
        SRC_A    = 2'd1,
        SRC_B    = 2'd2
    } src_e;

    typedef struct packed {
        src_e a_src;
        src_e b_src;
    } steer_t;

    localparam int SIDE_DN = 0;
    localparam int SIDE_UP = 1;
    localparam int N_SIDES = 2;

    function automatic wrap_mode_e mode_of(input logic [N_SIDES-1:0] wrapped);
        return wrap_mode_e'(wrapped);
    endfunction

    function automatic steer_t steer_of(input wrap_mode_e mode);
        steer_t s;
        unique case (mode)
            MODE_PASS:    begin s.a_src = SRC_A;    s.b_src = SRC_B;    end
            MODE_WRAP_DN: begin s.a_src = SRC_IDLE; s.b_src = SRC_A;    end
            MODE_WRAP_UP: begin s.a_src = SRC_B;    s.b_src = SRC_IDLE; end
            default:      begin s.a_src = SRC_IDLE; s.b_src = SRC_IDLE; end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/ring_wrap_side.sv
module ring_wrap_side #(
    parameter int HOLD = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic link_ok,
    output logic wrapped
);
    localparam int CNT_W = (HOLD > 1) ? $clog2(HOLD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD - 1);

    logic [CNT_W-1:0] good_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            wrapped  <= 1'b1;
            good_cnt <= '0;
        end else if (!link_ok) begin
            wrapped  <= 1'b1;
            good_cnt <= '0;
        end else if (wrapped) begin
            if (good_cnt == LAST) begin
                wrapped  <= 1'b0;
                good_cnt <= '0;
            end else begin
                good_cnt <= good_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ring_wrap_xbar.sv
module ring_wrap_xbar
    import ring_wrap_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  wrap_mode_e        mode,
    input  logic              a_vld,
    input  logic [DATA_W-1:0] a_dat,
    input  logic              b_vld,
    input  logic [DATA_W-1:0] b_dat,
    output logic              a_o_vld,
    output logic [DATA_W-1:0] a_o_dat,
    output logic              b_o_vld,
    output logic [DATA_W-1:0] b_o_dat
);
    steer_t steer;
    logic              a_n_vld, b_n_vld;
    logic [DATA_W-1:0] a_n_dat, b_n_dat;

    always_comb begin
        steer = steer_of(mode);
        unique case (steer.a_src)
            SRC_A:   begin a_n_vld = a_vld; a_n_dat = a_dat; end
            SRC_B:   begin a_n_vld = b_vld; a_n_dat = b_dat; end
            default: begin a_n_vld = 1'b0;  a_n_dat = '0;    end
        endcase
        unique case (steer.b_src)
            SRC_A:   begin b_n_vld = a_vld; b_n_dat = a_dat; end
            SRC_B:   begin b_n_vld = b_vld; b_n_dat = b_dat; end
            default: begin b_n_vld = 1'b0;  b_n_dat = '0;    end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_o_vld <= 1'b0;
            a_o_dat <= '0;
            b_o_vld <= 1'b0;
            b_o_dat <= '0;
        end else begin
            a_o_vld <= a_n_vld;
            a_o_dat <= a_n_dat;
            b_o_vld <= b_n_vld;
            b_o_dat <= b_n_dat;
        end
    end
endmodule

// File: rtl/ring_wrap_ctrl.sv
module ring_wrap_ctrl
    import ring_wrap_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int HOLD   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dn_link_ok,
    input  logic              up_link_ok,
    input  logic              a_in_vld,
    input  logic [DATA_W-1:0] a_in_dat,
    input  logic              b_in_vld,
    input  logic [DATA_W-1:0] b_in_dat,
    output logic              a_out_vld,
    output logic [DATA_W-1:0] a_out_dat,
    output logic              b_out_vld,
    output logic [DATA_W-1:0] b_out_dat,
    output logic [1:0]        wrap_status
);
    logic [N_SIDES-1:0] link_ok;
    logic [N_SIDES-1:0] side_wrapped;

    assign link_ok[SIDE_DN] = dn_link_ok;
    assign link_ok[SIDE_UP] = up_link_ok;

    for (genvar s = 0; s < N_SIDES; s++) begin : g_side
        ring_wrap_side #(.HOLD(HOLD)) u_side (
            .clk     (clk),
            .rst     (rst),
            .link_ok (link_ok[s]),
            .wrapped (side_wrapped[s])
        );
    end

    wrap_mode_e mode;
    assign mode        = mode_of(side_wrapped);
    assign wrap_status = side_wrapped;

    ring_wrap_xbar #(.DATA_W(DATA_W)) u_xbar (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .a_vld   (a_in_vld),
        .a_dat   (a_in_dat),
        .b_vld   (b_in_vld),
        .b_dat   (b_in_dat),
        .a_o_vld (a_out_vld),
        .a_o_dat (a_out_dat),
        .b_o_vld (b_out_vld),
        .b_o_dat (b_out_dat)
    );
endmodule

// File: rtl/ring_wrap_ctrl_chk.sv
module ring_wrap_ctrl_chk #(
    parameter int DATA_W = 32,
    parameter int HOLD   = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              dn_link_ok,
    input logic              up_link_ok,
    input logic              a_in_vld,
    input logic [DATA_W-1:0] a_in_dat,
    input logic              b_in_vld,
    input logic [DATA_W-1:0] b_in_dat,
    input logic              a_out_vld,
    input logic [DATA_W-1:0] a_out_dat,
    input logic              b_out_vld,
    input logic [DATA_W-1:0] b_out_dat,
    input logic [1:0]        wrap_status
);
    localparam int RUN_W = $clog2(HOLD + 1) + 1;

    logic [RUN_W-1:0] run_dn, run_up;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_dn <= '0;
            run_up <= '0;
        end else begin
            run_dn <= !dn_link_ok ? '0 : (run_dn >= RUN_W'(HOLD) ? run_dn : run_dn + 1'b1);
            run_up <= !up_link_ok ? '0 : (run_up >= RUN_W'(HOLD) ? run_up : run_up + 1'b1);
        end
    end

    // R1
    reset_isolated_chk: assert property (@(posedge clk) rst |=> wrap_status == 2'b11 && !a_out_vld && !b_out_vld);

    // R2
    pass_through_chk: assert property (@(posedge clk) disable iff (rst)
        $past(wrap_status) == 2'b00 |->
            a_out_vld == $past(a_in_vld) && a_out_dat == $past(a_in_dat) &&
            b_out_vld == $past(b_in_vld) && b_out_dat == $past(b_in_dat));

    // R3
    wrap_dn_chk: assert property (@(posedge clk) disable iff (rst)
        $past(wrap_status) == 2'b01 |->
            !a_out_vld && b_out_vld == $past(a_in_vld) && b_out_dat == $past(a_in_dat));

    // R4
    wrap_up_chk: assert property (@(posedge clk) disable iff (rst)
        $past(wrap_status) == 2'b10 |->
            !b_out_vld && a_out_vld == $past(b_in_vld) && a_out_dat == $past(b_in_dat));

    // R5
    isolate_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(wrap_status) == 2'b11 |-> !a_out_vld && !b_out_vld);

    // R6
    dn_wrap_set_chk: assert property (@(posedge clk) disable iff (rst) !dn_link_ok |=> wrap_status[0]);

    // R6
    up_wrap_set_chk: assert property (@(posedge clk) disable iff (rst) !up_link_ok |=> wrap_status[1]);

    // R7
    dn_unwrap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(wrap_status[0]) |-> run_dn >= RUN_W'(HOLD));

    // R7
    up_unwrap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(wrap_status[1]) |-> run_up >= RUN_W'(HOLD));
endmodule

bind ring_wrap_ctrl ring_wrap_ctrl_chk #(.DATA_W(DATA_W), .HOLD(HOLD)) u_chk (.*);

// File: tb/ring_wrap_ctrl_tb.sv
module ring_wrap_ctrl_tb;
    localparam int DW   = 32;
    localparam int HOLD = 16;

    typedef struct {
        logic          av;
        logic [DW-1:0] ad;
        logic          bv;
        logic [DW-1:0] bd;
        logic [1:0]    st;
        string         req;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dn_ok = 1'b0, up_ok = 1'b0;
    logic a_vld = 1'b0, b_vld = 1'b0;
    logic [DW-1:0] a_dat = '0, b_dat = '0;
    logic a_ov, b_ov;
    logic [DW-1:0] a_od, b_od;
    logic [1:0] st;

    int checks = 0;
    int errors = 0;
    exp_t q[$];

    logic m_dn, m_up;
    int   c_dn, c_up;

    always #4 clk = ~clk;

    ring_wrap_ctrl #(.DATA_W(DW), .HOLD(HOLD)) u_dut (
        .clk(clk), .rst(rst),
        .dn_link_ok(dn_ok), .up_link_ok(up_ok),
        .a_in_vld(a_vld), .a_in_dat(a_dat),
        .b_in_vld(b_vld), .b_in_dat(b_dat),
        .a_out_vld(a_ov), .a_out_dat(a_od),
        .b_out_vld(b_ov), .b_out_dat(b_od),
        .wrap_status(st)
    );

    task automatic side_upd(input logic ok, ref logic w, ref int c);
        if (!ok) begin w = 1'b1; c = 0; end
        else if (w) begin
            if (c == HOLD - 1) begin w = 1'b0; c = 0; end
            else c++;
        end
    endtask

    task automatic step(input logic dn, input logic up, input logic av, input logic [DW-1:0] ad,
                        input logic bv, input logic [DW-1:0] bd, input string req);
        exp_t e;
        @(negedge clk);
        dn_ok = dn; up_ok = up; a_vld = av; a_dat = ad; b_vld = bv; b_dat = bd;
        e.av = 1'b0; e.ad = '0; e.bv = 1'b0; e.bd = '0;
        case ({m_up, m_dn})
            2'b00: begin e.av = av; e.ad = ad; e.bv = bv; e.bd = bd; end
            2'b01: begin e.bv = av; e.bd = ad; end
            2'b10: begin e.av = bv; e.ad = bd; end
            default: ;
        endcase
        side_upd(dn, m_dn, c_dn);
        side_upd(up, m_up, c_up);
        e.st  = {m_up, m_dn};
        e.req = req;
        q.push_back(e);
    endtask

    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (a_ov !== e.av || a_od !== e.ad || b_ov !== e.bv || b_od !== e.bd || st !== e.st) begin
                errors++;
                $display("FAIL %s: got a=%b/%h b=%b/%h st=%b, expected a=%b/%h b=%b/%h st=%b",
                         e.req, a_ov, a_od, b_ov, b_od, st, e.av, e.ad, e.bv, e.bd, e.st);
            end
        end
    end

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        m_dn = 1'b1; m_up = 1'b1; c_dn = 0; c_up = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (st !== 2'b11 || a_ov !== 1'b0 || b_ov !== 1'b0) begin
            errors++;
            $display("FAIL R1: got st=%b a=%b b=%b, expected st=11 a=0 b=0", st, a_ov, b_ov);
        end
        rst = 1'b0;
        // R5 / R7: isolated while both links prove themselves for 16 edges
        for (int i = 0; i < HOLD; i++)
            step(1, 1, 1, 32'hA000_0000 + i, 1, 32'hB000_0000 + i, "R5_R7_bringup");
        // R2: pass-through with mixed valids
        for (int i = 0; i < 6; i++)
            step(1, 1, i[0], 32'h1111_0000 + i, !i[1], 32'h2222_0000 + i, "R2_pass");
        // R6 / R3 / R9: downstream drop, then recovery with glitch at count 10 (R8)
        step(0, 1, 1, 32'hC0DE_0001, 1, 32'hDEAD_0001, "R6_R9_dn_drop");
        for (int i = 0; i < 10; i++)
            step(1, 1, 1, 32'h3000_0000 + i, 1, 32'hBAD0_0000 + i, "R3_dn_wrap");
        step(0, 1, 1, 32'h3100_0000, 0, '0, "R8_dn_glitch");
        for (int i = 0; i < HOLD + 2; i++)
            step(1, 1, i[0], 32'h3200_0000 + i, 1, 32'hBAD1_0000 + i, "R3_R7_dn_recover");
        // R4: upstream drop, glitch at count 15 (R8)
        step(1, 0, 1, 32'h4000_0000, 1, 32'h5000_0000, "R6_up_drop");
        for (int i = 0; i < HOLD - 1; i++)
            step(1, 1, 1, 32'hBAD2_0000 + i, i[0], 32'h5100_0000 + i, "R4_up_wrap");
        step(1, 0, 1, 32'hBAD3_0000, 1, 32'h5200_0000, "R8_up_glitch_late");
        for (int i = 0; i < HOLD + 2; i++)
            step(1, 1, 1, 32'hBAD4_0000 + i, 1, 32'h5300_0000 + i, "R4_R7_up_recover");
        // R5: whole-neighbour loss on both sides, then staggered recovery
        step(0, 0, 1, 32'h6000_0000, 1, 32'h7000_0000, "R5_isolate");
        for (int i = 0; i < 4; i++)
            step(0, 1, 1, 32'h6100_0000 + i, 1, 32'h7100_0000 + i, "R5_isolate_hold");
        for (int i = 0; i < HOLD + 6; i++)
            step(1, 1, 1, 32'h6200_0000 + i, 1, 32'h7200_0000 + i, "R2_R7_staggered");
        @(negedge clk);
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule